// File: doc/BRIEF.md
# Token-Ring Almost-Full Status Broadcaster

This block shares one status bus between several devices that each keep a small set of queues. Every device carries a vector of almost-full flags, one flag per queue. In polled mode the devices form a ring. A one-cycle token travels from device to device on the write clock. The device that holds the token drives a captured copy of its flag vector onto the shared bus for exactly one cycle. At the same time it raises its token output for the next device and pulses a sync output. The token output of the last device feeds the token input of the first, so the scan repeats without end. A lone device in polled mode wires its token output back to its own token input and then drives the bus on every cycle.

After reset only the master device creates the token, and it does so on the first write-clock edge. Slaves wait until the token reaches them. When a device is not driving, its bus enable is low and its bus value is zero, so the outputs of all devices can be merged without contention.

In direct mode the token is not used. The bus continuously shows the device's live flags, the enable stays high, and the token and sync outputs stay low.

Top module: `afs_token_ring`

## Requirements
- R1: While reset is asserted in polled mode, bus_oe, tok_out and sync_o are 0 and bus_flags is all zero.
- R2: A master in polled mode drives tok_out, sync_o and bus_oe high during the first clock cycle after reset is released, even with tok_in low.
- R3: A slave in polled mode keeps tok_out low after reset until it samples tok_in high.
- R4: A tok_in of 1 sampled at a rising edge in polled mode makes the device own the bus for the following cycle. Ownership lasts one cycle, unless tok_in is sampled high again, in which case ownership continues.
- R5: During an owned cycle, bus_flags holds the af_flags value sampled at the edge that began the ownership. Later changes to af_flags do not alter bus_flags within that cycle.
- R6: In polled mode, sync_o and tok_out are both high exactly in the owned cycle.
- R7: In polled mode, when the device does not own the bus, bus_oe is 0 and bus_flags is all zero.
- R8: In direct mode (polled_mode = 0), bus_flags follows af_flags combinationally, bus_oe is 1, and tok_out and sync_o are 0. A tok_in pulse received in direct mode leaves no ownership after a return to polled mode.
- R9: A master in polled mode whose tok_out is wired to its own tok_in owns the bus on every cycle after reset.
- R10: The master starts the token only once per reset. If the token is lost, the master stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = this device starts the token after reset |
| polled_mode | input | 1 | 1 = token-ring polled mode, 0 = direct mode |
| tok_in | input | 1 | Token from the previous device in the ring |
| af_flags | input | NQ | Per-queue almost-full flags of this device |
| tok_out | output | 1 | Token to the next device; high during the owned cycle |
| sync_o | output | 1 | Marks the cycle in which this device drives the bus |
| bus_flags | output | NQ | Status bus value; zero while not driving |
| bus_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
A corrupted ownership bit shows up on the ports in the same cycle. It appears as an enable, token or sync pulse with no token to justify it, or as a missing pulse one edge after tok_in. In a ring, that error would either double the token or lose it for good. A lost or re-armed start latch shows within a few cycles of reset as a master that stays silent or that starts the token again. A stale or live-instead-of-captured flag register shows only during an owned cycle, when af_flags changes between the loading edge and the sampling point.

// File: rtl/afs_pkg.sv
package afs_pkg;
   localparam int unsigned AFS_DEF_NQ = 4;
   localparam int unsigned AFS_MAX_NQ = 32;

   typedef enum logic {
      AFS_DIRECT = 1'b0,
      AFS_POLLED = 1'b1
   } afs_mode_e;
endpackage

// File: rtl/afs_tok_ctl.sv
module afs_tok_ctl
   import afs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic is_master,
   input  afs_mode_e mode,
   input  logic tok_in,
   output logic own_o,
   output logic load_o
);
   logic armed;
   logic own;
   logic load;

   // next-cycle ownership: token arrival, or one-time master start
   assign load = (mode == AFS_POLLED) & (tok_in | (armed & is_master));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
         own   <= 1'b0;
      end else begin
         armed <= 1'b0;
         own   <= load;
      end
   end

   assign own_o  = own;
   assign load_o = load;

   // R4: a token seen in polled mode grants the next cycle
   a_r4_token_grants: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == AFS_POLLED && tok_in) |=> own);

   // R4: without token or start, ownership drops after one cycle
   a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!tok_in && !armed) |=> !own);

   // R2: the armed master in polled mode starts the token
   a_r2_master_start: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && is_master && mode == AFS_POLLED) |=> own);

   // R10: the start latch never re-arms outside reset
   a_r10_start_once: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !armed);
endmodule

// File: rtl/afs_bus_drive.sv
module afs_bus_drive
   import afs_pkg::*;
#(
   parameter int unsigned NQ = AFS_DEF_NQ
)(
   input  logic          clk,
   input  logic          rst_n,
   input  afs_mode_e     mode,
   input  logic          load,
   input  logic          own,
   input  logic [NQ-1:0] af_flags,
   output logic [NQ-1:0] bus_flags,
   output logic          bus_oe
);
   logic [NQ-1:0] snap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap <= '0;
      else if (load) snap <= af_flags;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_lane
      assign bus_flags[q] = (mode == AFS_POLLED) ? (own & snap[q]) : af_flags[q];
   end

   assign bus_oe = (mode == AFS_POLLED) ? own : 1'b1;

   // R5: owned cycle shows the flags captured at the loading edge
   a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mode != AFS_POLLED) || (bus_flags == $past(af_flags)));
endmodule

// File: rtl/afs_token_ring.sv
module afs_token_ring
   import afs_pkg::*;
#(
   parameter int unsigned NQ = AFS_DEF_NQ
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_master,
   input  logic          polled_mode,
   input  logic          tok_in,
   input  logic [NQ-1:0] af_flags,
   output logic          tok_out,
   output logic          sync_o,
   output logic [NQ-1:0] bus_flags,
   output logic          bus_oe
);
   if (NQ < 1 || NQ > AFS_MAX_NQ) begin : g_bad_nq
      $error("afs_token_ring: NQ out of range");
   end

   afs_mode_e mode;
   logic      own;
   logic      load;

   assign mode = polled_mode ? AFS_POLLED : AFS_DIRECT;

   afs_tok_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_master (is_master),
      .mode      (mode),
      .tok_in    (tok_in),
      .own_o     (own),
      .load_o    (load)
   );

   afs_bus_drive #(.NQ(NQ)) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .load      (load),
      .own       (own),
      .af_flags  (af_flags),
      .bus_flags (bus_flags),
      .bus_oe    (bus_oe)
   );

   assign tok_out = polled_mode & own;
   assign sync_o  = polled_mode & own;

   // R7: an idle polled device neither drives nor leaks flags
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (polled_mode && !tok_out) |-> (!bus_oe && bus_flags == '0));

   // R8: direct mode keeps the ring signals low and the bus enabled
   a_r8_direct_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !polled_mode |-> (!sync_o && !tok_out && bus_oe && bus_flags == af_flags));

   // R6: a token pulse is always accompanied by an enabled bus
   a_r6_pulse_drives: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |-> (sync_o && bus_oe));
endmodule

// File: tb/sim_afs_token_ring.sv
module sim_afs_token_ring;
   localparam int NQ = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          is_master = 1'b0;
   logic          polled_mode = 1'b1;
   logic          tb_tok = 1'b0;
   logic          loop_en = 1'b0;
   logic [NQ-1:0] af_flags = '0;
   logic          tok_in, tok_out, sync_o, bus_oe;
   logic [NQ-1:0] bus_flags;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   assign tok_in = loop_en ? tok_out : tb_tok;

   afs_token_ring #(.NQ(NQ)) u0 (
      .clk(clk), .rst_n(rst_n), .is_master(is_master), .polled_mode(polled_mode),
      .tok_in(tok_in), .af_flags(af_flags), .tok_out(tok_out), .sync_o(sync_o),
      .bus_flags(bus_flags), .bus_oe(bus_oe)
   );

   // {tok_in, flags[3:0], exp_oe, exp_bus[3:0], exp_tok}
   localparam logic [10:0] VEC [8] = '{
      {1'b0, 4'h5, 1'b0, 4'h0, 1'b0},
      {1'b1, 4'hA, 1'b1, 4'hA, 1'b1},
      {1'b0, 4'h3, 1'b0, 4'h0, 1'b0},
      {1'b1, 4'hF, 1'b1, 4'hF, 1'b1},
      {1'b1, 4'h6, 1'b1, 4'h6, 1'b1},
      {1'b0, 4'h9, 1'b0, 4'h0, 1'b0},
      {1'b1, 4'h0, 1'b1, 4'h0, 1'b1},
      {1'b0, 4'hC, 1'b0, 4'h0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state, slave, polled
      repeat (3) cyc();
      check("R1 oe", bus_oe, 0);
      check("R1 tok", tok_out, 0);
      check("R1 sync", sync_o, 0);
      check("R1 bus", bus_flags, 0);

      // R3: slave idles after reset
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         cyc();
         check("R3 slave idle", tok_out, 0);
      end

      // R4/R5/R6/R7: table walk
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         tb_tok   = VEC[i][10];
         af_flags = VEC[i][9:6];
         cyc();
         check("R4/R7 oe", bus_oe, VEC[i][5]);
         check("R5/R7 bus", bus_flags, VEC[i][4:1]);
         check("R4 tok", tok_out, VEC[i][0]);
         check("R6 sync", sync_o, VEC[i][0]);
      end

      // R5: flags change inside the owned cycle
      @(negedge clk); tb_tok = 1'b1; af_flags = 4'h9;
      cyc();
      @(negedge clk); tb_tok = 1'b0; af_flags = 4'h2;
      #1;
      check("R5 snapshot held", bus_flags, 4'h9);
      cyc();
      check("R7 released", bus_oe, 0);

      // R8: direct mode
      @(negedge clk); polled_mode = 1'b0; af_flags = 4'h7; tb_tok = 1'b1;
      #1;
      check("R8 live bus", bus_flags, 4'h7);
      check("R8 oe", bus_oe, 1);
      cyc();
      check("R8 tok", tok_out, 0);
      check("R8 sync", sync_o, 0);
      @(negedge clk); af_flags = 4'hB;
      #1;
      check("R8 live follow", bus_flags, 4'hB);
      @(negedge clk); polled_mode = 1'b1; tb_tok = 1'b0;
      cyc();
      check("R8 token ignored", tok_out, 0);
      check("R8 token ignored oe", bus_oe, 0);

      // R2/R10: master start once
      @(negedge clk); rst_n = 1'b0; is_master = 1'b1; af_flags = 4'h3;
      @(negedge clk); rst_n = 1'b1;
      cyc();
      check("R2 master tok", tok_out, 1);
      check("R2 master oe", bus_oe, 1);
      check("R2 master bus", bus_flags, 4'h3);
      cyc();
      check("R4 master drop", tok_out, 0);
      for (int k = 0; k < 4; k++) begin
         cyc();
         check("R10 no restart", tok_out, 0);
      end

      // R9: self loop
      @(negedge clk); rst_n = 1'b0; loop_en = 1'b1; af_flags = 4'h5;
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 5; k++) begin
         cyc();
         check("R9 loop tok", tok_out, 1);
         check("R9 loop bus", bus_flags, 4'h5);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule